// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is a slave receiver for a three-wire serial audio link. An external host supplies the bit clock, the frame sync (channel select) and the serial data, all in the system clock domain. The receiver finds bit-clock rising edges by comparing the bit clock with its value on the previous system clock. It samples frame sync and data on each such edge and turns every frame into one parallel pair of signed stereo samples.

Two static configuration inputs set the framing. `fmt_sel` chooses one of three justifications. `width_sel` chooses a sample width of 16, 18 or 20 bits. Samples are two's complement and arrive MSB first. Shorter samples are placed at the top of the 20-bit outputs, with the low bits zero. The outputs stay at zero until the receiver has seen frames of a consistent length. Only then do it raise `locked_o` and issue sample pairs with a one-cycle `valid_o` strobe.

Top module: `aud_serial_rx`

## Requirements
- R1: Frame sync and data are taken only in the system cycle where `bclk_i` is high and was low on the previous system cycle. A change of `sd_i` while the bit clock stays high has no effect on the outputs.
- R2: With `fmt_sel` = 01 (left-justified), frame sync high marks the left half-frame. The sample MSB is the first bit sampled after a frame-sync change.
- R3: With `fmt_sel` = 00 (standard I2S), frame sync low marks the left half-frame. The sample MSB comes one bit clock after the frame-sync change, and the bit sampled at the change still belongs to the previous half-frame.
- R4: With `fmt_sel[1]` = 1 (right-justified, codes 10 and 11), the sample is the last N bits sampled before the next frame-sync change. Frame sync high marks the left half-frame.
- R5: `width_sel` codes 00, 01 and 10 select N = 16, 18 and 20 bits, and 11 also selects 20. An N-bit sample is placed in bits 19 down to 20-N of the output, with the lower bits zero.
- R6: In the two MSB-first modes, bits after the first N bits of a half-frame do not change the sample.
- R7: A frame is a left half-frame followed by a right half-frame. `locked_o` rises when a frame ends whose total bit-clock count equals that of the previous frame, where both frames have halves of at least N bits. That same frame produces the first `valid_o`.
- R8: When a frame ends with a bit count different from the previous frame, `locked_o` drops, `valid_o` stays low, and both sample outputs are forced to zero. Two further equal frames restore lock.
- R9: A frame that has a half-frame shorter than N bits drops lock, even if its total count is unchanged.
- R10: `valid_o` is a single-cycle pulse. It appears on the system cycle after the bit-clock rising edge that ends the right half-frame, and only while `locked_o` is high. The sample outputs hold between pulses.
- R11: During and after reset, `left_o`, `right_o`, `valid_o` and `locked_o` are zero. The first two bit-clock rises after reset do not count as frame boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock from the host |
| fs_i | input | 1 | Frame sync / channel select from the host |
| sd_i | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Justification: 00 I2S, 01 left-justified, 1x right-justified |
| width_sel | input | 2 | Sample width: 00 16, 01 18, 10/11 20 bits |
| left_o | output | 20 | Left sample, signed, MSB-aligned |
| right_o | output | 20 | Right sample, signed, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| locked_o | output | 1 | Frame synchronisation confirmed |

## Verification
The bit-clock edge that closes a right half-frame has two jobs in one cycle. It judges the lock from the finished frame's count, and it captures the first bit of the next half-frame into a freshly cleared word. The bench provokes this collision in three ways: by lengthening one half by a single bit, by shortening one half while keeping the frame total, and by running every mode back to back. A behavioural model built on queues predicts lock, strobe and sample values for every system cycle, and the design's outputs are compared with it on every cycle.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned AUD_SW = 20;
  localparam int unsigned NB_W   = $clog2(AUD_SW + 1);

  function automatic logic is_i2s(input logic [1:0] f);
    return (f == 2'b00);
  endfunction

  function automatic logic is_lsb(input logic [1:0] f);
    return f[1];
  endfunction

  function automatic logic [NB_W-1:0] word_bits(input logic [1:0] w);
    case (w)
      2'b00:   return NB_W'(AUD_SW - 4);
      2'b01:   return NB_W'(AUD_SW - 2);
      default: return NB_W'(AUD_SW);
    endcase
  endfunction

  // keep the low n bits of a shift window, then move them to the top
  function automatic logic [AUD_SW-1:0] lsb_align(input logic [AUD_SW-1:0] s,
                                                  input logic [NB_W-1:0] n);
    logic [AUD_SW-1:0] m;
    m = (AUD_SW'(1) << n) - AUD_SW'(1);
    return (s & m) << (NB_W'(AUD_SW) - n);
  endfunction
endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge
  import aud_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic sd_i,
  input  logic i2s_i,
  output logic bit_stb,
  output logic bit_val,
  output logic bnd,
  output logic close_left
);
  logic       bclk_q;
  logic       fs_smp;
  logic       fs_e_q;
  logic [1:0] prime;
  logic       fs_e;

  assign bit_stb    = bclk_i & ~bclk_q;
  assign bit_val    = sd_i;
  // I2S: sync delayed one bit and inverted, so high always marks left
  assign fs_e       = i2s_i ? ~fs_smp : fs_i;
  assign bnd        = bit_stb && (prime == 2'd2) && (fs_e != fs_e_q);
  assign close_left = fs_e_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b1;
      fs_smp <= 1'b0;
      fs_e_q <= 1'b0;
      prime  <= 2'd0;
    end else begin
      bclk_q <= bclk_i;
      if (bit_stb) begin
        fs_smp <= fs_i;
        fs_e_q <= fs_e;
        if (prime != 2'd2) prime <= prime + 2'd1;
      end
    end
  end

  // R1
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  // R11
  prime_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prime != 2'd2) |-> !bnd);
endmodule

// File: rtl/aud_rx_collect.sv
module aud_rx_collect
  import aud_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              bnd,
  input  logic              lsb_i,
  input  logic [NB_W-1:0]   nbits,
  output logic [AUD_SW-1:0] word,
  output logic [CNT_W-1:0]  half_len
);
  logic [AUD_SW-1:0] w;
  logic [AUD_SW-1:0] s;
  logic [CNT_W-1:0]  cnt;
  logic              in_word;
  logic [NB_W-1:0]   idx;

  assign in_word  = (cnt < CNT_W'(nbits));
  assign idx      = NB_W'(AUD_SW - 1) - cnt[NB_W-1:0];
  assign word     = lsb_i ? lsb_align(s, nbits) : w;
  assign half_len = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w   <= '0;
      s   <= '0;
      cnt <= '0;
    end else if (bit_stb) begin
      if (bnd) begin
        w   <= {bit_val, {(AUD_SW-1){1'b0}}};
        s   <= {{(AUD_SW-1){1'b0}}, bit_val};
        cnt <= CNT_W'(1);
      end else begin
        if (in_word) w[idx] <= bit_val;
        s <= {s[AUD_SW-2:0], bit_val};
        if (cnt != '1) cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2
  restart_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && bnd) |=> (half_len == CNT_W'(1)));

  // R6
  tail_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !bnd && !in_word) |=> $stable(w));
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd,
  input  logic              close_left,
  input  logic [AUD_SW-1:0] word,
  input  logic [CNT_W-1:0]  half_len,
  input  logic [NB_W-1:0]   nbits,
  output logic [AUD_SW-1:0] left_o,
  output logic [AUD_SW-1:0] right_o,
  output logic              valid_o,
  output logic              locked_o
);
  localparam int unsigned LEN_W = CNT_W + 1;

  logic              armed, have_left, have_prev;
  logic [AUD_SW-1:0] lw;
  logic [CNT_W-1:0]  ll;
  logic [LEN_W-1:0]  prev_len, flen;
  logic              frame_done, good, lock_nx;

  assign frame_done = bnd && armed && !close_left && have_left;
  assign good       = (ll >= CNT_W'(nbits)) && (half_len >= CNT_W'(nbits));
  assign flen       = LEN_W'(ll) + LEN_W'(half_len);
  assign lock_nx    = good && have_prev && (flen == prev_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; have_left <= 1'b0; have_prev <= 1'b0;
      lw <= '0; ll <= '0; prev_len <= '0;
      left_o <= '0; right_o <= '0; valid_o <= 1'b0; locked_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bnd) begin
        if (!armed) begin
          armed <= 1'b1;
        end else if (close_left) begin
          lw        <= word;
          ll        <= half_len;
          have_left <= 1'b1;
        end else if (have_left) begin
          have_left <= 1'b0;
          prev_len  <= flen;
          have_prev <= good;
          locked_o  <= lock_nx;
          valid_o   <= lock_nx;
          left_o    <= lock_nx ? lw   : '0;
          right_o   <= lock_nx ? word : '0;
        end
      end
    end
  end

  // R7
  lock_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> valid_o);

  // R8
  muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (left_o == '0 && right_o == '0));

  // R9
  short_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (half_len < CNT_W'(nbits))) |=> !locked_o);

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R10
  strobe_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> locked_o);
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fs_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        width_sel,
  output logic [AUD_SW-1:0] left_o,
  output logic [AUD_SW-1:0] right_o,
  output logic              valid_o,
  output logic              locked_o
);
  logic              bit_stb, bit_val, bnd, close_left;
  logic [NB_W-1:0]   nbits;
  logic [AUD_SW-1:0] word;
  logic [CNT_W-1:0]  half_len;

  assign nbits = word_bits(width_sel);

  aud_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fs_i(fs_i), .sd_i(sd_i),
    .i2s_i(is_i2s(fmt_sel)), .bit_stb(bit_stb), .bit_val(bit_val),
    .bnd(bnd), .close_left(close_left)
  );

  aud_rx_collect #(.CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .bnd(bnd), .lsb_i(is_lsb(fmt_sel)), .nbits(nbits),
    .word(word), .half_len(half_len)
  );

  aud_rx_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .close_left(close_left),
    .word(word), .half_len(half_len), .nbits(nbits),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .locked_o(locked_o)
  );
endmodule

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fs = 1'b0, sd = 1'b0;
  logic [1:0] fmt = 2'b01, wsel = 2'b10;
  logic [19:0] left_o, right_o;
  logic valid_o, locked_o;

  aud_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fs_i(fs), .sd_i(sd),
    .fmt_sel(fmt), .width_sel(wsel), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .locked_o(locked_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_bprev, m_fsprev, m_pend, m_pend_left, m_armed, m_have_left, m_have_prev;
  int m_rises, m_ll, m_prev_len;
  bit m_q[$];
  logic [19:0] m_lw;
  bit exp_locked, exp_valid;
  logic [19:0] exp_l, exp_r;
  int cap_valids, multi_valid;
  bit prev_valid;
  logic [19:0] cap_l, cap_r;

  function automatic int nb_of(input logic [1:0] w);
    return (w == 2'b00) ? 16 : (w == 2'b01) ? 18 : 20;
  endfunction

  function automatic logic [19:0] m_word();
    logic [19:0] r = '0;
    int nb = nb_of(wsel);
    for (int i = 0; i < nb; i++) begin
      int k = fmt[1] ? (m_q.size() - nb + i) : i;
      if (k >= 0 && k < m_q.size()) r[19-i] = m_q[k];
    end
    return r;
  endfunction

  task automatic m_close(input bit left);
    if (!m_armed) m_armed = 1;
    else if (left) begin
      m_lw = m_word(); m_ll = m_q.size(); m_have_left = 1;
    end else if (m_have_left) begin
      int len = m_q.size();
      int nb = nb_of(wsel);
      bit good = (m_ll >= nb) && (len >= nb);
      bit lk = good && m_have_prev && ((m_ll + len) == m_prev_len);
      m_have_left = 0;
      exp_locked = lk; exp_valid = lk;
      exp_l = lk ? m_lw : 20'h0;
      exp_r = lk ? m_word() : 20'h0;
      m_prev_len = m_ll + len; m_have_prev = good;
    end
    m_q.delete();
  endtask

  task automatic m_bit(input bit f, input bit d);
    if (fmt == 2'b00) begin
      if (m_pend) begin m_close(m_pend_left); m_pend = 0; end
      if (m_rises >= 1 && f != m_fsprev) begin m_pend = 1; m_pend_left = (m_fsprev == 0); end
    end else if (m_rises >= 1 && f != m_fsprev) begin
      m_close(m_fsprev == 1);
    end
    m_q.push_back(d);
    m_fsprev = f;
    m_rises++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_bprev = 1; m_fsprev = 0; m_pend = 0; m_pend_left = 0; m_armed = 0;
      m_have_left = 0; m_have_prev = 0; m_rises = 0; m_ll = 0; m_prev_len = 0;
      m_q.delete(); m_lw = '0;
      exp_locked = 0; exp_valid = 0; exp_l = '0; exp_r = '0;
      cap_valids = 0; multi_valid = 0; prev_valid = 0; cap_l = '0; cap_r = '0;
    end else begin
      // per-cycle comparison against the model (R7 lock, R10 strobe, R5 data)
      chk("R7 per-cycle locked", 64'(locked_o), 64'(exp_locked));
      chk("R10 per-cycle valid", 64'(valid_o), 64'(exp_valid));
      chk("R5 per-cycle samples", {24'h0, left_o, right_o}, {24'h0, exp_l, exp_r});
      if (valid_o) begin cap_valids++; cap_l = left_o; cap_r = right_o; end
      if (valid_o && prev_valid) multi_valid++;
      prev_valid = valid_o;
      exp_valid = 0;
      if (bclk && !m_bprev) m_bit(fs, sd);
      m_bprev = bclk;
    end
  end

  // ---------------- stimulus ----------------
  int g_nb;
  bit g_fill, g_glitch;

  task automatic tick; @(posedge clk); #1; endtask

  task automatic send_bit(input bit f, input bit d);
    tick; bclk = 0; fs = f; sd = d;
    tick; bclk = 1;
    tick; if (g_glitch) sd = ~d;
    tick;
  endtask

  function automatic bit gen(input int j, input int h, input logic [19:0] v);
    int p;
    if (fmt == 2'b00)  p = j - 1;
    else if (fmt[1])   p = j - (h - g_nb);
    else               p = j;
    if (p >= 0 && p < g_nb) return v[g_nb-1-p];
    return g_fill;
  endfunction

  function automatic bit lvl(input bit left);
    return (fmt == 2'b00) ? ~left : left;
  endfunction

  task automatic send_half(input bit left, input int h, input logic [19:0] v);
    for (int j = 0; j < h; j++) send_bit(lvl(left), gen(j, h, v));
  endtask

  task automatic send_frame(input int hl, input int hr, input logic [19:0] lv, input logic [19:0] rv);
    send_half(1, hl, lv); send_half(0, hr, rv);
  endtask

  task automatic start(input logic [1:0] f, input logic [1:0] w, input bit fill);
    rst_n = 0; fmt = f; wsel = w; g_nb = nb_of(w); g_fill = fill; g_glitch = 0;
    bclk = 0; fs = lvl(0); sd = 0;
    tick; tick; tick; rst_n = 1; tick;
    for (int i = 0; i < 4; i++) send_bit(lvl(0), 1'b0);
  endtask

  task automatic tail;
    for (int i = 0; i < 3; i++) send_bit(lvl(1), 1'b0);
    repeat (4) tick;
  endtask

  function automatic logic [19:0] val(input int k);
    logic [19:0] m = (20'h1 << g_nb) - 20'h1;
    return (20'(k) * 20'h3B1D7 + 20'h5A4C3) & m;
  endfunction

  function automatic logic [19:0] al(input logic [19:0] v);
    return v << (20 - g_nb);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    report();
  end

  initial begin
    // R11 reset state
    start(2'b01, 2'b10, 0);
    chk("R11 reset locked", 64'(locked_o), 0);
    chk("R11 reset valid", 64'(valid_o), 0);
    chk("R11 reset samples", {24'h0, left_o, right_o}, 0);

    // R2 left-justified 20-bit, 40 bit clocks per frame
    start(2'b01, 2'b10, 0);
    send_frame(20, 20, val(1), val(2)); send_frame(20, 20, val(3), val(4));
    send_frame(20, 20, val(5), val(6)); tail;
    chk("R7 pairs after lock", cap_valids, 2);
    chk("R7 locked", 64'(locked_o), 1);
    chk("R2 left", 64'(cap_l), 64'(al(val(5))));
    chk("R2 right", 64'(cap_r), 64'(al(val(6))));

    // R6 / R5 16-bit left-justified, trailing ones ignored, low bits zero
    start(2'b01, 2'b00, 1);
    send_frame(24, 24, val(7), val(8)); send_frame(24, 24, val(9), val(10)); tail;
    chk("R6 left trailing ignored", 64'(cap_l), 64'(al(val(9))));
    chk("R5 right 16-bit aligned", 64'(cap_r), 64'(al(val(10))));

    // R3 I2S 18-bit
    start(2'b00, 2'b01, 0);
    send_frame(32, 32, val(11), val(12)); send_frame(32, 32, val(13), val(14));
    send_frame(32, 32, val(15), val(16)); tail;
    chk("R3 left", 64'(cap_l), 64'(al(val(15))));
    chk("R3 right", 64'(cap_r), 64'(al(val(16))));

    // R4 right-justified code 10, 20-bit, leading ones ignored
    start(2'b10, 2'b10, 1);
    send_frame(32, 32, val(17), val(18)); send_frame(32, 32, val(19), val(20)); tail;
    chk("R4 left code10", 64'(cap_l), 64'(al(val(19))));
    chk("R4 right code10", 64'(cap_r), 64'(al(val(20))));

    // R4 / R5 right-justified code 11, 16-bit
    start(2'b11, 2'b00, 0);
    send_frame(24, 24, val(21), val(22)); send_frame(24, 24, val(23), val(24)); tail;
    chk("R4 left code11", 64'(cap_l), 64'(al(val(23))));
    chk("R5 right code11 16-bit", 64'(cap_r), 64'(al(val(24))));

    // R5 width code 11 selects 20 bits
    start(2'b01, 2'b11, 0);
    send_frame(24, 24, val(25), val(26)); send_frame(24, 24, val(27), val(28)); tail;
    chk("R5 width11 left", 64'(cap_l), 64'(al(val(27))));
    chk("R5 width11 right", 64'(cap_r), 64'(al(val(28))));

    // R1 data glitches while bit clock is high
    start(2'b01, 2'b10, 0);
    g_glitch = 1;
    send_frame(24, 24, val(29), val(30)); send_frame(24, 24, val(31), val(32)); tail;
    g_glitch = 0;
    chk("R1 left glitch ignored", 64'(cap_l), 64'(al(val(31))));
    chk("R1 right glitch ignored", 64'(cap_r), 64'(al(val(32))));

    // R8 frame length change drops lock and mutes
    start(2'b01, 2'b10, 0);
    send_frame(20, 20, val(33), val(34)); send_frame(20, 20, val(35), val(36));
    send_frame(20, 20, val(37), val(38)); send_frame(21, 20, val(39), val(40)); tail;
    chk("R8 lock dropped", 64'(locked_o), 0);
    chk("R8 muted", {24'h0, left_o, right_o}, 0);
    chk("R8 no pair on change", cap_valids, 2);

    // R8 relock after two equal frames
    start(2'b01, 2'b10, 0);
    send_frame(20, 20, val(41), val(42)); send_frame(20, 20, val(43), val(44));
    send_frame(21, 20, val(45), val(46)); send_frame(21, 20, val(47), val(48)); tail;
    chk("R8 relocked", 64'(locked_o), 1);
    chk("R8 relock pairs", cap_valids, 2);
    chk("R8 relock left", 64'(cap_l), 64'(al(val(47))));

    // R9 short half with unchanged total
    start(2'b01, 2'b10, 0);
    send_frame(20, 20, val(49), val(50)); send_frame(20, 20, val(51), val(52));
    send_frame(18, 22, val(53), val(54)); tail;
    chk("R9 short half unlocks", 64'(locked_o), 0);
    chk("R9 muted", {24'h0, left_o, right_o}, 0);
    chk("R9 pairs", cap_valids, 1);

    // R10 strobe never longer than one cycle across the whole run
    chk("R10 single-cycle strobe", multi_valid, 0);

    report();
  end
endmodule